// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block drives the feedback multiplier of a fractional-N clock synthesizer. From a nominal integer multiplier and divider it forms an unsigned fixed-point word with 16 fractional bits. It then moves that word along a triangular sweep, so the synthesized frequency swings either evenly about the nominal value (center spread) or only below it (down spread). Spreading the frequency this way spreads the clock's energy over a band and lowers the peak of its emissions.

A one-cycle `tick` input advances the sweep. Each modulation period starts at the minimum frequency, climbs to the maximum and falls back to the minimum. The sweep depth comes from a 3-bit depth code and the period length from a rate select. The mode, depth, rate, multiplier and divider are sampled only when a period starts, so the sweep never jumps in the middle. A power-down input halts the sweep and returns the output to the plain nominal ratio. The loop filter, the VCO, the noise shaping of the fractional bits and the output dividers are handled elsewhere.

Top module: `ssm_profile_gen`

## Requirements
- R1: The nominal word is floor(M * 65536 / N), with M on `mult_m` (12 bits, 1 to 2048) and N on `div_n` (11 bits, 1 to 1024). After reset, `mult_word` shows this value from the second clock edge onward, with no offset, and `period_start` stays low.
- R2: `spread_mode` is encoded as 0 = off, 1 = center, 2 = down, 3 = off. In either off encoding, `mult_word` equals the nominal word sampled at the last period start, on every tick.
- R3: Depth codes 0 to 4 give a peak-to-peak span S = floor(nom * (10 << code) / 4000), where nom is the nominal word. This is ±0.125 % to ±2 % of nominal for center spread and 0.25 % to 4 % below nominal for down spread. Codes 5, 6 and 7 give S = 0 (no spread).
- R4: In center spread the sweep runs from nom - floor(S/2) up to nom + S - floor(S/2).
- R5: In down spread the maximum equals nom exactly and the minimum is nom - S.
- R6: One period is 2H ticks. Each of the first H-1 rising ticks adds step = floor(S/H). The H-th rising tick lands exactly on the maximum. The falling half mirrors this, and the H-th falling tick lands exactly on the minimum. The word never passes either extreme.
- R7: `rate_fast` = 0 selects H = HALF_SLOW (default 32). `rate_fast` = 1 selects H = HALF_FAST (default 8), which is four times the modulation rate.
- R8: `period_start` is high for exactly one clock after each tick that starts a period. That is the first tick after reset or power-down, and then every 2H ticks, each time with the word at its minimum.
- R9: Changes to mode, depth, rate, M or N between period starts have no effect until the next period start.
- R10: While `tick` is low, the sweep position and `mult_word` hold.
- R11: While `pwr_dn` is high, ticks are ignored, `period_start` is low and `mult_word` shows the plain nominal word. The first tick after release starts a new period at its minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Halts the sweep and returns the output to nominal |
| tick | input | 1 | Advances the sweep by one step |
| mult_m | input | 12 | Nominal multiplier M |
| div_n | input | 11 | Nominal divider N |
| spread_mode | input | 2 | 0 off, 1 center, 2 down, 3 off |
| depth_code | input | 3 | Sweep depth code |
| rate_fast | input | 1 | 0 slow rate, 1 fast rate |
| mult_word | output | 28 | Instantaneous multiplier word, 16 fractional bits |
| period_start | output | 1 | One-cycle pulse at each period start |

## Verification
The hardest case to reach from the ports is a configuration change that lands in the middle of a sweep. Here the new depth must stay invisible through the remaining rise and fall, and then take over exactly at the next minimum. The stimulus starts a center sweep, raises the depth a few ticks in, pauses the ticks at the peak, and then runs on across the boundary. It checks the old maximum at the peak and the new minimum and maximum afterwards. A power-down pulse in the middle of a rise then confirms that the sweep restarts from a fresh minimum.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [1:0] {
    SS_OFF     = 2'd0,
    SS_CENTER  = 2'd1,
    SS_DOWN    = 2'd2,
    SS_OFF_ALT = 2'd3
  } ss_mode_e;

  // depth code c selects span = nom * (DEPTH_BASE << c) / DEPTH_DEN
  localparam int unsigned DEPTH_BASE  = 10;
  localparam int unsigned DEPTH_DEN   = 4000;
  localparam int unsigned DEPTH_CODES = 5;

  function automatic logic [63:0] nominal_ratio(input logic [63:0] m,
                                                input logic [63:0] n,
                                                input int unsigned frac);
    if (n == 64'd0) return 64'd0;
    return (m << frac) / n;
  endfunction

  function automatic logic [63:0] span_of(input logic [63:0] nom,
                                          input logic [2:0]  code);
    logic [63:0] k;
    if (32'(code) >= DEPTH_CODES) return 64'd0;
    k = 64'(DEPTH_BASE) << code;
    return (nom * k) / 64'(DEPTH_DEN);
  endfunction

  function automatic bit is_spread(input ss_mode_e mode);
    return (mode == SS_CENTER) || (mode == SS_DOWN);
  endfunction

  function automatic logic [63:0] offset_of(input ss_mode_e mode,
                                            input logic [63:0] span);
    case (mode)
      SS_CENTER: return span >> 1;
      SS_DOWN:   return span;
      default:   return 64'd0;
    endcase
  endfunction

endpackage

// File: rtl/ssm_nominal.sv
module ssm_nominal #(
  parameter int M_W    = 12,
  parameter int N_W    = 11,
  parameter int FRAC_W = 16,
  parameter int WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [M_W-1:0]    mult_m,
  input  logic [N_W-1:0]    div_n,
  output logic [WORD_W-1:0] nom_q
);
  import ssm_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nom_q <= '0;
    else        nom_q <= WORD_W'(nominal_ratio(64'(mult_m), 64'(div_n), FRAC_W));
  end
endmodule

// File: rtl/ssm_span.sv
module ssm_span #(
  parameter int WORD_W    = 28,
  parameter int HALF_SLOW = 32,
  parameter int HALF_FAST = 8
) (
  input  ssm_pkg::ss_mode_e mode,
  input  logic [2:0]        depth,
  input  logic              fast,
  input  logic [WORD_W-1:0] nom,
  output logic [WORD_W-1:0] span,
  output logic [WORD_W-1:0] offset,
  output logic [WORD_W-1:0] step
);
  import ssm_pkg::*;

  logic [63:0] span64;
  logic [63:0] half64;

  always_comb begin
    span64 = is_spread(mode) ? span_of(64'(nom), depth) : 64'd0;
    half64 = fast ? 64'(HALF_FAST) : 64'(HALF_SLOW);
    span   = WORD_W'(span64);
    offset = WORD_W'(offset_of(mode, span64));
    step   = WORD_W'(span64 / half64);
  end
endmodule

// File: rtl/ssm_ramp.sv
module ssm_ramp #(
  parameter int WORD_W = 28,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              tick,
  input  logic [WORD_W-1:0] span,
  input  logic [WORD_W-1:0] step,
  input  logic [CNT_W-1:0]  half_m1,
  output logic [WORD_W-1:0] pos,
  output logic              primed,
  output logic              load_evt,
  output logic              peak_evt,
  output logic              period_start
);
  logic [CNT_W-1:0] cnt;
  logic             falling;
  logic             at_end;

  assign at_end   = (cnt == half_m1);
  assign load_evt = tick && !pwr_dn && (!primed || (falling && at_end));
  assign peak_evt = tick && !pwr_dn && primed && !falling && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; cnt <= '0; falling <= 1'b0; primed <= 1'b0; period_start <= 1'b0;
    end else if (pwr_dn) begin
      pos <= '0; cnt <= '0; falling <= 1'b0; primed <= 1'b0; period_start <= 1'b0;
    end else begin
      period_start <= load_evt;
      if (load_evt) begin
        pos     <= '0;
        cnt     <= '0;
        falling <= 1'b0;
        primed  <= 1'b1;
      end else if (tick && primed) begin
        if (at_end) begin
          // only the rising half reaches here: land exactly on the peak
          cnt     <= '0;
          falling <= 1'b1;
          pos     <= span;
        end else begin
          cnt <= cnt + CNT_W'(1);
          pos <= falling ? pos - step : pos + step;
        end
      end
    end
  end
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen #(
  parameter  int M_W       = 12,
  parameter  int N_W       = 11,
  parameter  int FRAC_W    = 16,
  parameter  int HALF_SLOW = 32,
  parameter  int HALF_FAST = 8,
  localparam int WORD_W    = M_W + FRAC_W,
  localparam int HALF_MAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST,
  localparam int CNT_W     = $clog2(HALF_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              tick,
  input  logic [M_W-1:0]    mult_m,
  input  logic [N_W-1:0]    div_n,
  input  logic [1:0]        spread_mode,
  input  logic [2:0]        depth_code,
  input  logic              rate_fast,
  output logic [WORD_W-1:0] mult_word,
  output logic              period_start
);
  import ssm_pkg::*;

  logic [WORD_W-1:0] nom_q, span_n, off_n, step_n;
  logic [WORD_W-1:0] nom_a, span_a, off_a, step_a;
  logic              fast_a;
  ss_mode_e          mode_a;
  logic [CNT_W-1:0]  half_m1;
  logic [WORD_W-1:0] pos;
  logic              primed, load_evt, peak_evt;
  logic [WORD_W:0]   swept;

  ssm_nominal #(.M_W(M_W), .N_W(N_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W)) u_nominal (
    .clk(clk), .rst_n(rst_n), .mult_m(mult_m), .div_n(div_n), .nom_q(nom_q)
  );

  ssm_span #(.WORD_W(WORD_W), .HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_span (
    .mode(ss_mode_e'(spread_mode)), .depth(depth_code), .fast(rate_fast),
    .nom(nom_q), .span(span_n), .offset(off_n), .step(step_n)
  );

  // active configuration: replaced only at a period start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nom_a <= '0; span_a <= '0; off_a <= '0; step_a <= '0;
      fast_a <= 1'b0; mode_a <= SS_OFF;
    end else if (pwr_dn) begin
      span_a <= '0; off_a <= '0; step_a <= '0; mode_a <= SS_OFF;
    end else if (load_evt) begin
      nom_a  <= nom_q;
      span_a <= span_n;
      off_a  <= off_n;
      step_a <= step_n;
      fast_a <= rate_fast;
      mode_a <= ss_mode_e'(spread_mode);
    end
  end

  assign half_m1 = fast_a ? CNT_W'(HALF_FAST - 1) : CNT_W'(HALF_SLOW - 1);

  ssm_ramp #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tick(tick),
    .span(span_a), .step(step_a), .half_m1(half_m1),
    .pos(pos), .primed(primed), .load_evt(load_evt), .peak_evt(peak_evt),
    .period_start(period_start)
  );

  assign swept     = {1'b0, nom_a} + {1'b0, pos} - {1'b0, off_a};
  assign mult_word = primed ? swept[WORD_W-1:0] : nom_q;

endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk #(
  parameter int WORD_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic              tick,
  input logic              period_start,
  input logic [WORD_W-1:0] mult_word,
  input logic              primed,
  input logic [WORD_W-1:0] pos,
  input logic [WORD_W-1:0] span_a,
  input logic [WORD_W-1:0] nom_a,
  input logic [WORD_W-1:0] off_a,
  input logic [1:0]        mode_a,
  input logic              load_evt,
  input logic              peak_evt
);
  assert_pos_in_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> pos <= span_a);

  assert_peak_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peak_evt |=> pos == span_a);

  assert_down_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && mode_a == 2'd2) |-> mult_word <= nom_a);

  assert_center_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && mode_a == 2'd1) |-> mult_word >= nom_a - off_a);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  assert_load_at_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (period_start && pos == '0));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !tick && !pwr_dn) |=> ($stable(pos) && $stable(mult_word)));

  assert_pwrdn_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!primed && !period_start));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !pwr_dn) |=> ($stable(span_a) && $stable(nom_a)));
endmodule

bind ssm_profile_gen ssm_profile_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tick(tick),
  .period_start(period_start), .mult_word(mult_word), .primed(primed),
  .pos(pos), .span_a(span_a), .nom_a(nom_a), .off_a(off_a),
  .mode_a(mode_a), .load_evt(load_evt), .peak_evt(peak_evt)
);

// File: tb/test_ssm_profile_gen.sv
`timescale 1ns/1ps
module test_ssm_profile_gen;
  localparam int HS = 32;
  localparam int HF = 8;

  logic        clk = 1'b0;
  logic        rst_n, pwr_dn, tick, rate_fast;
  logic [11:0] mult_m;
  logic [10:0] div_n;
  logic [1:0]  spread_mode;
  logic [2:0]  depth_code;
  logic [27:0] mult_word;
  logic        period_start;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ssm_profile_gen i_ssm_profile_gen (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tick(tick),
    .mult_m(mult_m), .div_n(div_n), .spread_mode(spread_mode),
    .depth_code(depth_code), .rate_fast(rate_fast),
    .mult_word(mult_word), .period_start(period_start)
  );

  // mode, depth, fast, M, N, expected minimum word, expected maximum word
  localparam logic [84:0] VEC [8] = '{
    {2'd1, 3'd3, 1'b0, 12'd4,    11'd1,    28'd259523,  28'd264765},
    {2'd2, 3'd3, 1'b1, 12'd4,    11'd1,    28'd256902,  28'd262144},
    {2'd1, 3'd4, 1'b1, 12'd8,    11'd2,    28'd256902,  28'd267387},
    {2'd2, 3'd0, 1'b0, 12'd100,  11'd3,    28'd2179072, 28'd2184533},
    {2'd0, 3'd3, 1'b0, 12'd4,    11'd1,    28'd262144,  28'd262144},
    {2'd1, 3'd6, 1'b1, 12'd4,    11'd1,    28'd262144,  28'd262144},
    {2'd3, 3'd2, 1'b1, 12'd4,    11'd1,    28'd262144,  28'd262144},
    {2'd2, 3'd4, 1'b0, 12'd2048, 11'd1024, 28'd125830,  28'd131072}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [1:0] md, input logic [2:0] dp, input logic fs,
                         input logic [11:0] m, input logic [10:0] n);
    tick = 1'b0; pwr_dn = 1'b1;
    spread_mode = md; depth_code = dp; rate_fast = fs; mult_m = m; div_n = n;
    cyc(1);
    pwr_dn = 1'b0;
    cyc(3);
  endtask

  initial begin
    rst_n = 1'b0; pwr_dn = 1'b0; tick = 1'b0; rate_fast = 1'b0;
    mult_m = 12'd4; div_n = 11'd1; spread_mode = 2'd0; depth_code = 3'd0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(mult_word == 28'd262144, "R1 reset word", mult_word, 262144);
    chk(period_start == 1'b0, "R1 reset pulse", period_start, 0);

    for (int i = 0; i < 8; i++) begin
      logic [84:0] v;
      int h, stp, lo, hi;
      string req;
      v  = VEC[i];
      lo = int'(v[55:28]);
      hi = int'(v[27:0]);
      h  = v[79] ? HF : HS;
      stp = (hi - lo) / h;
      if (v[82:80] > 3'd4)        req = "R3 unused depth";
      else if (v[84:83] == 2'd1)  req = "R4 center";
      else if (v[84:83] == 2'd2)  req = "R5 down";
      else                        req = "R2 off";
      restart(v[84:83], v[82:80], v[79], v[78:67], v[66:56]);
      tick = 1'b1;
      cyc(1);
      chk(mult_word == lo, {req, " start minimum"}, mult_word, lo);
      chk(period_start == 1'b1, "R8 first pulse", period_start, 1);
      cyc(h);
      chk(mult_word == hi, {req, " R7 peak after H ticks"}, mult_word, hi);
      chk(period_start == 1'b0, "R8 no pulse at peak", period_start, 0);
      cyc(h / 2);
      chk(mult_word == hi - (h / 2) * stp, "R6 falling midpoint", mult_word, hi - (h / 2) * stp);
      cyc(h - h / 2);
      chk(mult_word == lo, "R6 back to minimum", mult_word, lo);
      chk(period_start == 1'b1, "R8 pulse after 2H ticks", period_start, 1);
      tick = 1'b0;
    end

    // R9: depth change in mid-sweep waits for the next period start
    restart(2'd1, 3'd3, 1'b0, 12'd4, 11'd1);
    tick = 1'b1;
    cyc(1);
    cyc(5);
    depth_code = 3'd4;
    cyc(HS - 5);
    chk(mult_word == 28'd264765, "R9 old depth peak", mult_word, 264765);
    // R10: no ticks, the word holds
    tick = 1'b0;
    cyc(4);
    chk(mult_word == 28'd264765, "R10 hold without tick", mult_word, 264765);
    chk(period_start == 1'b0, "R10 no pulse while idle", period_start, 0);
    tick = 1'b1;
    cyc(HS);
    chk(mult_word == 28'd256902, "R9 new depth minimum", mult_word, 256902);
    chk(period_start == 1'b1, "R9 boundary pulse", period_start, 1);
    cyc(HS);
    chk(mult_word == 28'd267387, "R9 new depth peak", mult_word, 267387);

    // R11: power-down mid-rise
    cyc(5);
    pwr_dn = 1'b1;
    cyc(1);
    chk(mult_word == 28'd262144, "R11 nominal in power-down", mult_word, 262144);
    chk(period_start == 1'b0, "R11 pulse low in power-down", period_start, 0);
    cyc(4);
    chk(mult_word == 28'd262144, "R11 ticks ignored", mult_word, 262144);
    pwr_dn = 1'b0;
    cyc(1);
    chk(period_start == 1'b1, "R11 restart pulse", period_start, 1);
    chk(mult_word == 28'd256902, "R11 restart at minimum", mult_word, 256902);
    tick = 1'b0;
    cyc(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule